// File: doc/BRIEF.md
# Balanced-Sparsity Sparse MAC Element

This processing element consumes one broadcast group of activations per cycle together with a compressed kernel slice. The slice keeps a fixed number of non-zero weights for every group of eight activations. Each stored weight comes with a short position index. A lane multiplexer uses the index to choose the matching activation from the group, and each lane then multiplies the selected activation by its weight. The lane products are summed, and the sum is added into a wide partial-sum accumulator.

Every group carries the same count of non-zero weights. The element therefore accepts a new group on every cycle, never stalls, and keeps all of its multipliers busy. The path is split into three register stages, and a valid flag travels through the stages alongside the data. A start flag that comes with the first group of a new accumulation makes the accumulator load that group's sum in place of adding it.

Top module: `spmac_pe`

## Requirements
- R1: While rst_ni is low, psum_o is 0 and psum_valid_o is 0.
- R2: Lane k takes its 3-bit index from wgt_idx_i[3k+2:3k] and its 8-bit weight from wgt_val_i[8k+7:8k]. The index p (0 to 7) selects the activation act_i[8p+7:8p].
- R3: Activations and weights are signed two's complement. The group sum is the exact signed sum of the lane products.
- R4: A group that is presented with act_valid_i high before clock edge e makes psum_valid_o high for exactly one cycle, after edge e+2. This makes the latency three edges. Groups presented back-to-back on every cycle each produce their own result with no stall.
- R5: When a valid group carries acc_start_i high, psum_o becomes that group's sum alone, and no earlier state is added to it.
- R6: When a valid group carries acc_start_i low, psum_o becomes the previous psum_o plus that group's sum.
- R7: On cycles with act_valid_i low, the accumulator is untouched and no result is signalled. acc_start_i has no effect on those cycles.
- R8: If two lanes carry the same index, both products are summed, each with its own weight.
- R9: The accumulator has 2*DW + 8 + clog2(NNZ) bits, which is 25 with the defaults DW=8 and NNZ=2. It adds 256 groups of the largest product, (-128)*(-128) on every lane, without wrapping.
- R10: The number of non-zero lanes per group, NNZ, is a parameter for 2 or 3 kept weights out of 8. Each lane has its own multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_valid_i | input | 1 | A group is presented this cycle |
| acc_start_i | input | 1 | First group of a new accumulation |
| act_i | input | GROUP*DW | Broadcast activation group, position p at bits [DW*p +: DW] |
| wgt_val_i | input | NNZ*DW | Non-zero weight values, one per lane |
| wgt_idx_i | input | NNZ*IDXW | Position index of each lane's weight |
| psum_o | output | ACCW | Signed partial-sum accumulator |
| psum_valid_o | output | 1 | psum_o was updated by a group this cycle |

## Verification
The hardest situation to reach is an index pattern that repeats a position. Normal pruned data never produces it, yet the element must still sum both products. The stimulus sweeps all 64 index pairs over a group of distinct activations, so every duplicate pair appears next to every distinct pair. A second hard case is the top of the accumulator range. It is reached by streaming 256 back-to-back groups of the most negative value times itself, and the check is that the final sum does not wrap. Start pulses are also driven during idle cycles to show that they are ignored.

// File: rtl/spmac_pkg.sv
package spmac_pkg;
  // accumulator wide enough for 256 groups of full-scale products
  function automatic int acc_w(int dw, int nnz);
    return 2 * dw + 8 + $clog2(nnz);
  endfunction
endpackage

// File: rtl/spmac_lane_mul.sv
module spmac_lane_mul #(
  parameter int GROUP = 8,
  parameter int NNZ   = 2,
  parameter int DW    = 8,
  parameter int IDXW  = $clog2(GROUP)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [GROUP*DW-1:0]   act_i,
  input  logic [NNZ*DW-1:0]     wval_i,
  input  logic [NNZ*IDXW-1:0]   widx_i,
  output logic [NNZ*2*DW-1:0]   prod_o
);
  logic signed [DW-1:0] act_a [GROUP];

  for (genvar g = 0; g < GROUP; g++) begin : g_unpack
    assign act_a[g] = act_i[g*DW +: DW];
  end

  for (genvar l = 0; l < NNZ; l++) begin : g_lane
    logic [IDXW-1:0]        idx;
    logic signed [DW-1:0]   a_sel;
    logic signed [DW-1:0]   w;
    logic signed [2*DW-1:0] p_d;
    logic signed [2*DW-1:0] p_q;

    assign idx   = widx_i[l*IDXW +: IDXW];
    assign w     = wval_i[l*DW +: DW];
    assign a_sel = act_a[idx];
    assign p_d   = a_sel * w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   p_q <= '0;
      else if (en_i) p_q <= p_d;
    end

    assign prod_o[l*2*DW +: 2*DW] = p_q;
  end
endmodule

// File: rtl/spmac_sum.sv
module spmac_sum #(
  parameter int NNZ  = 2,
  parameter int DW   = 8,
  parameter int ACCW = 25
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [NNZ*2*DW-1:0] prod_i,
  output logic [ACCW-1:0]     sum_o
);
  localparam int PW = 2 * DW;

  logic [ACCW-1:0] sum_d;

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < NNZ; k++) begin
      sum_d = sum_d + {{(ACCW-PW){prod_i[k*PW+PW-1]}}, prod_i[k*PW +: PW]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_o <= '0;
    else if (en_i) sum_o <= sum_d;
  end
endmodule

// File: rtl/spmac_accum.sv
module spmac_accum #(
  parameter int ACCW = 25
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            start_i,
  input  logic [ACCW-1:0] sum_i,
  output logic [ACCW-1:0] acc_o,
  output logic            valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) acc_o <= start_i ? sum_i : acc_o + sum_i;
    end
  end
endmodule

// File: rtl/spmac_pe.sv
module spmac_pe #(
  parameter int GROUP = 8,
  parameter int NNZ   = 2,
  parameter int DW    = 8,
  localparam int IDXW = $clog2(GROUP),
  localparam int ACCW = spmac_pkg::acc_w(DW, NNZ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_valid_i,
  input  logic                acc_start_i,
  input  logic [GROUP*DW-1:0] act_i,
  input  logic [NNZ*DW-1:0]   wgt_val_i,
  input  logic [NNZ*IDXW-1:0] wgt_idx_i,
  output logic [ACCW-1:0]     psum_o,
  output logic                psum_valid_o
);
  logic [NNZ*2*DW-1:0] prod;
  logic [ACCW-1:0]     sum;
  logic v1, s1, v2, s2;

  // control rides alongside data; start only counts on valid groups
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; s1 <= 1'b0;
      v2 <= 1'b0; s2 <= 1'b0;
    end else begin
      v1 <= act_valid_i;
      s1 <= act_valid_i & acc_start_i;
      v2 <= v1;
      s2 <= s1;
    end
  end

  spmac_lane_mul #(.GROUP(GROUP), .NNZ(NNZ), .DW(DW), .IDXW(IDXW)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (act_valid_i),
    .act_i  (act_i),
    .wval_i (wgt_val_i),
    .widx_i (wgt_idx_i),
    .prod_o (prod)
  );

  spmac_sum #(.NNZ(NNZ), .DW(DW), .ACCW(ACCW)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (v1),
    .prod_i (prod),
    .sum_o  (sum)
  );

  spmac_accum #(.ACCW(ACCW)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v2),
    .start_i (s2),
    .sum_i   (sum),
    .acc_o   (psum_o),
    .valid_o (psum_valid_o)
  );
endmodule

// File: rtl/spmac_pe_chk.sv
module spmac_pe_chk #(
  parameter int DW   = 8,
  parameter int NNZ  = 2,
  parameter int ACCW = 25
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            act_valid_i,
  input logic            acc_start_i,
  input logic [ACCW-1:0] psum_o,
  input logic            psum_valid_o
);
  localparam longint LIM = longint'(NNZ) * (64'sd1 <<< (2 * DW - 2));

  logic [1:0] cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt <= '0;
    else if (cnt != 3) cnt <= cnt + 2'd1;
  end

  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (psum_o == '0 && !psum_valid_o);
    end
  end

  // R4
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd3) |-> (psum_valid_o == $past(act_valid_i, 3)));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd3 && !$past(act_valid_i, 3)) |-> $stable(psum_o));

  // R5
  start_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd3 && psum_valid_o && $past(act_valid_i && acc_start_i, 3)) |->
    (longint'($signed(psum_o)) <= LIM && longint'($signed(psum_o)) >= -LIM));
endmodule

bind spmac_pe spmac_pe_chk #(.DW(DW), .NNZ(NNZ), .ACCW(ACCW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .act_valid_i  (act_valid_i),
  .acc_start_i  (acc_start_i),
  .psum_o       (psum_o),
  .psum_valid_o (psum_valid_o)
);

// File: tb/spmac_pe_test.sv
module spmac_pe_test;
  localparam int GROUP = 8;
  localparam int NNZ   = 2;
  localparam int DW    = 8;
  localparam int IDXW  = 3;
  localparam int ACCW  = 2 * DW + 8 + $clog2(NNZ);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic act_valid_i = 1'b0;
  logic acc_start_i = 1'b0;
  logic [GROUP*DW-1:0] act_i = '0;
  logic [NNZ*DW-1:0]   wgt_val_i = '0;
  logic [NNZ*IDXW-1:0] wgt_idx_i = '0;
  logic [ACCW-1:0]     psum_o;
  logic                psum_valid_o;

  always #10 clk_i = ~clk_i;

  spmac_pe #(.GROUP(GROUP), .NNZ(NNZ), .DW(DW)) uut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  longint acc_m = 0, last_out = 0;
  longint exp_val [16];
  int     exp_cyc [16];
  string  exp_tag [16];
  int wr = 0, rd = 0;

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint gsum(logic [GROUP*DW-1:0] a, logic [NNZ*DW-1:0] w,
                                  logic [NNZ*IDXW-1:0] ix);
    longint s = 0;
    for (int l = 0; l < NNZ; l++) begin
      int p = int'(ix[l*IDXW +: IDXW]);
      s += longint'($signed(a[p*DW +: DW])) * longint'($signed(w[l*DW +: DW]));
    end
    return s;
  endfunction

  task automatic step(input bit v, input bit st, input logic [GROUP*DW-1:0] a,
                      input logic [NNZ*DW-1:0] w, input logic [NNZ*IDXW-1:0] ix,
                      input string tag);
    longint got;
    @(negedge clk_i);
    cyc++;
    got = longint'($signed(psum_o));
    if (psum_valid_o) begin
      if (rd == wr) chk(0, "R4 unexpected result", 1, 0);
      else begin
        chk(cyc == exp_cyc[rd], "R4 latency", cyc, exp_cyc[rd]);
        chk(got == exp_val[rd], exp_tag[rd], got, exp_val[rd]);
        last_out = exp_val[rd];
        rd = (rd + 1) % 16;
      end
    end else begin
      if (rd != wr && exp_cyc[rd] == cyc) chk(0, "R4 missing result", 0, 1);
      chk(got == last_out, "R7 hold", got, last_out);
    end
    act_valid_i = v; acc_start_i = st; act_i = a; wgt_val_i = w; wgt_idx_i = ix;
    if (v) begin
      longint s = gsum(a, w, ix);
      acc_m = st ? s : acc_m + s;
      exp_val[wr] = acc_m;
      exp_cyc[wr] = cyc + 3;
      exp_tag[wr] = tag;
      wr = (wr + 1) % 16;
    end
  endtask

  task automatic idle(input int n, input bit st);
    for (int i = 0; i < n; i++) step(0, st, {GROUP*DW{1'b1}}, '1, '1, "R7");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [GROUP*DW-1:0] a;
    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk(psum_o == '0, "R1 psum", longint'(psum_o), 0);
    chk(psum_valid_o == 1'b0, "R1 valid", longint'(psum_valid_o), 0);
    rst_ni = 1'b1;
    idle(2, 0);

    // R2 R8: all index pairs, distinct activations, back-to-back (R4)
    for (int p = 0; p < GROUP; p++) a[p*DW +: DW] = 8'(p * 29 - 100);
    for (int i0 = 0; i0 < GROUP; i0++)
      for (int i1 = 0; i1 < GROUP; i1++)
        step(1, 1, a, {8'sd3, -8'sd5}, {3'(i1), 3'(i0)}, (i0 == i1) ? "R8" : "R2");
    idle(4, 0);

    // R3: signed value sweep on lanes picking positions 5 and 2
    for (int av = -128; av < 128; av++)
      for (int wv = -128; wv < 128; wv += 17) begin
        a = '0;
        for (int p = 0; p < GROUP; p++) a[p*DW +: DW] = 8'(p * 7 + av);
        a[5*DW +: DW] = 8'(av);
        a[2*DW +: DW] = 8'(-av - 1);
        step(1, 1, a, {8'(wv), 8'(-wv)}, {3'd2, 3'd5}, "R3");
      end
    idle(4, 0);

    // R5 R6 R7: chains with idle gaps and stray start pulses
    for (int c = 0; c < 4; c++) begin
      for (int g = 0; g < 12; g++) begin
        for (int p = 0; p < GROUP; p++) a[p*DW +: DW] = 8'(c * 31 + g * 11 - p * 9);
        step(1, g == 0, a, {8'(g - 6), 8'(c * 40 - 70)}, {3'(g % 8), 3'((g + c) % 8)},
             g == 0 ? "R5" : "R6");
        if (g % 4 == 3) idle(2, 1);
      end
      idle(4, 1);
    end

    // R9: 256 full-scale groups, no wraparound; R10 all lanes active
    a = {GROUP{8'h80}};
    for (int g = 0; g < 256; g++) step(1, g == 0, a, {NNZ{8'h80}}, {3'd7, 3'd0}, "R9");
    idle(4, 0);
    chk(longint'($signed(psum_o)) == 256 * NNZ * 16384, "R9 final",
        longint'($signed(psum_o)), 256 * NNZ * 16384);
    finish_run();
  end
endmodule